// File: doc/BRIEF.md
# CAN Protocol Status Tracker

This block holds the host-visible protocol status word of a CAN FD controller. The bit-level protocol engine reports to it through one-cycle event pulses. These pulses cover an error-free frame completion, an error with its type code, a received FD-format frame with its rate-switch and error-state bits, a protocol exception, and an 11-recessive-bit detection during bus-off recovery. The engine also supplies some level signals: a flag marking that the current frame is in a rate-switched data phase, the transmit and receive error counters, the bus-off flag, the current activity, and a measured transmitter loop delay.

The block folds all of this into one 32-bit read-only word. Error codes go to one of two fields. An error seen in the rate-switched data phase lands in the data-phase field, and any other error lands in the arbitration-phase field. A host read strobe has side effects. Both error fields return to the "no change" code, and the sticky exception and FD-received flags clear. If an event arrives in the same cycle as the read, the event wins. Every field is registered, so an event is visible in the word one clock after its pulse. The host samples the word in the cycle in which it raises the read strobe.

Top module: `can_status_word`

## Requirements
- R1: After reset the word reads 0x0000_0707. Both error fields hold 7 and every other field holds 0.
- R2: An error pulse with the data-phase flag low writes its code into bits 2:0 one cycle later. Bits 10:8 are left alone. The codes are 0 none, 1 stuff, 2 form, 3 ack, 4 bit1, 5 bit0, 6 CRC, 7 no change.
- R3: An error pulse with the data-phase flag high writes its code into bits 10:8, using the same encoding. Bits 2:0 are left alone.
- R4: An error-free completion pulse writes 0 into bits 10:8 when the data-phase flag is high, and into bits 2:0 otherwise.
- R5: A host read sets both error fields to 7. When an event targets a field in the same cycle, that field takes the event code instead.
- R6: An 11-recessive-bit pulse writes 5 into bits 2:0.
- R7: Bit 6 (warning) is 1 when either error counter is at or above 96.
- R8: Bit 7 follows the engine bus-off flag. Bit 5 (passive) is 1 when either counter is at or above 128, but it is held at 0 while the node is bus-off.
- R9: Bits 4:3 follow the engine activity (0 synchronizing, 1 idle, 2 receiver, 3 transmitter). A protocol exception pulse forces them to 0 and sets bit 14. Bit 14 stays set until a host read in a cycle without a new exception.
- R10: A received FD frame pulse sets bit 13 and copies its rate-switch bit into bit 12 and its error-state bit into bit 11. Bit 13 clears on a host read unless a new FD frame arrives in that same cycle. Bits 12:11 keep their value across reads.
- R11: Bits 22:16 hold the measured delay plus the configured offset, saturated at 127.
- R12: Bits 31:23 and bit 15 always read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_rd | input | 1 | Host read strobe of the status word |
| ev_ok | input | 1 | Frame completed without error |
| ev_err | input | 1 | Error detected |
| ev_err_code | input | 3 | Error type code for ev_err |
| in_data_phase | input | 1 | Current frame is in a rate-switched data phase |
| ev_fd_rx | input | 1 | FD-format frame received |
| rx_brs | input | 1 | Rate-switch bit of the received FD frame |
| rx_esi | input | 1 | Error-state bit of the received FD frame |
| ev_pexc | input | 1 | Protocol exception event |
| ev_rec11 | input | 1 | 11 recessive bits seen during bus-off recovery |
| tx_err_cnt | input | 8 | Transmit error counter |
| rx_err_cnt | input | 8 | Receive error counter |
| bus_off | input | 1 | Engine bus-off flag |
| act_in | input | 2 | Engine activity state |
| tdc_meas | input | 7 | Measured TX-to-RX loop delay |
| tdc_offset | input | 7 | Configured delay offset |
| status_word | output | 32 | Protocol status word |

## Verification
Error pulses are sent with the data-phase flag both low and high, so that a routing fault shows up as a code in the wrong field. Completion pulses and bus-off recovery pulses are mixed in between, to check which event overwrites which. Host reads are issued both alone and in the same cycle as an error, an exception or an FD frame. This separates a correct read reset from one that wrongly overrides the event. The counters are stepped across 95/96 and 127/128, with and without bus-off, and delay sums are chosen below, at and above 127 to expose an overflow in place of saturation.

// File: rtl/can_psr_pkg.sv
package can_psr_pkg;
  typedef enum logic [2:0] {
    EC_NONE  = 3'd0,
    EC_STUFF = 3'd1,
    EC_FORM  = 3'd2,
    EC_ACK   = 3'd3,
    EC_BIT1  = 3'd4,
    EC_BIT0  = 3'd5,
    EC_CRC   = 3'd6,
    EC_NOCHG = 3'd7
  } err_code_e;

  typedef enum logic [1:0] {
    ACT_SYNC = 2'd0,
    ACT_IDLE = 2'd1,
    ACT_RX   = 2'd2,
    ACT_TX   = 2'd3
  } act_e;

  localparam int unsigned NUM_ERR_FIELDS = 2;
  localparam int unsigned FLD_ARB        = 0;
  localparam int unsigned FLD_DATA       = 1;
endpackage

// File: rtl/can_err_field.sv
module can_err_field
  import can_psr_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      upd_err,
  input  err_code_e err_code,
  input  logic      upd_rec11,
  input  logic      upd_ok,
  input  logic      host_rd,
  output err_code_e field_q
);
  err_code_e field_d;
  logic      field_en;

  // priority: error > recovery pulse > clean completion > host read
  always_comb begin
    field_d  = field_q;
    field_en = upd_err | upd_rec11 | upd_ok | host_rd;
    if (upd_err)        field_d = err_code;
    else if (upd_rec11) field_d = EC_BIT0;
    else if (upd_ok)    field_d = EC_NONE;
    else if (host_rd)   field_d = EC_NOCHG;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        field_q <= EC_NOCHG;
    else if (field_en) field_q <= field_d;
  end

  assert_err_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
    upd_err |=> field_q == $past(err_code));
  assert_rd_nochange_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (host_rd && !upd_err && !upd_rec11 && !upd_ok) |=> field_q == EC_NOCHG);
  assert_rec11_bit0_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_rec11 && !upd_err) |=> field_q == EC_BIT0);
  assert_ok_clear_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_ok && !upd_err && !upd_rec11) |=> field_q == EC_NONE);
endmodule

// File: rtl/can_node_state.sv
module can_node_state
  import can_psr_pkg::*;
#(
  parameter int unsigned CNT_W    = 8,
  parameter int unsigned WARN_LIM = 96,
  parameter int unsigned PASS_LIM = 128
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CNT_W-1:0] tx_cnt,
  input  logic [CNT_W-1:0] rx_cnt,
  input  logic             bus_off,
  input  logic [1:0]       act_in,
  input  logic             ev_pexc,
  input  logic             host_rd,
  output logic             warn_q,
  output logic             passive_q,
  output logic             busoff_q,
  output act_e             act_q,
  output logic             pexc_q
);
  localparam logic [CNT_W:0] WARN_V = (CNT_W+1)'(WARN_LIM);
  localparam logic [CNT_W:0] PASS_V = (CNT_W+1)'(PASS_LIM);

  logic warn_d, passive_d, pexc_d;
  act_e act_d;

  always_comb begin
    warn_d    = ({1'b0, tx_cnt} >= WARN_V) || ({1'b0, rx_cnt} >= WARN_V);
    passive_d = (({1'b0, tx_cnt} >= PASS_V) || ({1'b0, rx_cnt} >= PASS_V)) && !bus_off;
    act_d     = ev_pexc ? ACT_SYNC : act_e'(act_in);
    pexc_d    = pexc_q;
    if (ev_pexc)      pexc_d = 1'b1;
    else if (host_rd) pexc_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      warn_q    <= 1'b0;
      passive_q <= 1'b0;
      busoff_q  <= 1'b0;
      act_q     <= ACT_SYNC;
      pexc_q    <= 1'b0;
    end else begin
      warn_q    <= warn_d;
      passive_q <= passive_d;
      busoff_q  <= bus_off;
      act_q     <= act_d;
      pexc_q    <= pexc_d;
    end
  end

  assert_warn_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_cnt >= CNT_W'(WARN_LIM)) |=> warn_q);
  assert_busoff_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
    bus_off |=> (busoff_q && !passive_q));
  assert_pexc_act_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ev_pexc |=> (act_q == ACT_SYNC && pexc_q));
endmodule

// File: rtl/can_fd_rx_flags.sv
module can_fd_rx_flags (
  input  logic clk,
  input  logic rst_n,
  input  logic ev_fd_rx,
  input  logic rx_brs,
  input  logic rx_esi,
  input  logic host_rd,
  output logic fd_seen_q,
  output logic brs_q,
  output logic esi_q
);
  logic fd_seen_d;

  always_comb begin
    fd_seen_d = fd_seen_q;
    if (ev_fd_rx)     fd_seen_d = 1'b1;
    else if (host_rd) fd_seen_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) fd_seen_q <= 1'b0;
    else        fd_seen_q <= fd_seen_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      brs_q <= 1'b0;
      esi_q <= 1'b0;
    end else if (ev_fd_rx) begin
      brs_q <= rx_brs;
      esi_q <= rx_esi;
    end
  end

  assert_fd_capture_R10: assert property (@(posedge clk) disable iff (!rst_n)
    ev_fd_rx |=> (fd_seen_q && brs_q == $past(rx_brs) && esi_q == $past(rx_esi)));
  assert_fd_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (!ev_fd_rx && !host_rd) |=> $stable(fd_seen_q));
endmodule

// File: rtl/can_status_word.sv
module can_status_word
  import can_psr_pkg::*;
#(
  parameter int unsigned CNT_W    = 8,
  parameter int unsigned TDC_W    = 7,
  parameter int unsigned WARN_LIM = 96,
  parameter int unsigned PASS_LIM = 128
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             host_rd,
  input  logic             ev_ok,
  input  logic             ev_err,
  input  logic [2:0]       ev_err_code,
  input  logic             in_data_phase,
  input  logic             ev_fd_rx,
  input  logic             rx_brs,
  input  logic             rx_esi,
  input  logic             ev_pexc,
  input  logic             ev_rec11,
  input  logic [CNT_W-1:0] tx_err_cnt,
  input  logic [CNT_W-1:0] rx_err_cnt,
  input  logic             bus_off,
  input  logic [1:0]       act_in,
  input  logic [TDC_W-1:0] tdc_meas,
  input  logic [TDC_W-1:0] tdc_offset,
  output logic [31:0]      status_word
);
  localparam logic [TDC_W:0] TDC_MAX = {1'b0, {TDC_W{1'b1}}};
  localparam int unsigned    PAD_W   = 16 - TDC_W;

  // error-code routing: index FLD_ARB / FLD_DATA
  logic      upd_err_v   [NUM_ERR_FIELDS];
  logic      upd_ok_v    [NUM_ERR_FIELDS];
  logic      upd_rec11_v [NUM_ERR_FIELDS];
  err_code_e field_v     [NUM_ERR_FIELDS];

  always_comb begin
    upd_err_v[FLD_ARB]    = ev_err & ~in_data_phase;
    upd_err_v[FLD_DATA]   = ev_err &  in_data_phase;
    upd_ok_v[FLD_ARB]     = ev_ok  & ~in_data_phase;
    upd_ok_v[FLD_DATA]    = ev_ok  &  in_data_phase;
    upd_rec11_v[FLD_ARB]  = ev_rec11;
    upd_rec11_v[FLD_DATA] = 1'b0;
  end

  for (genvar g = 0; g < NUM_ERR_FIELDS; g++) begin : g_err
    can_err_field u_fld (
      .clk       (clk),
      .rst_n     (rst_n),
      .upd_err   (upd_err_v[g]),
      .err_code  (err_code_e'(ev_err_code)),
      .upd_rec11 (upd_rec11_v[g]),
      .upd_ok    (upd_ok_v[g]),
      .host_rd   (host_rd),
      .field_q   (field_v[g])
    );
  end

  logic warn_q, passive_q, busoff_q, pexc_q;
  act_e act_q;

  can_node_state #(
    .CNT_W    (CNT_W),
    .WARN_LIM (WARN_LIM),
    .PASS_LIM (PASS_LIM)
  ) u_node (
    .clk       (clk),
    .rst_n     (rst_n),
    .tx_cnt    (tx_err_cnt),
    .rx_cnt    (rx_err_cnt),
    .bus_off   (bus_off),
    .act_in    (act_in),
    .ev_pexc   (ev_pexc),
    .host_rd   (host_rd),
    .warn_q    (warn_q),
    .passive_q (passive_q),
    .busoff_q  (busoff_q),
    .act_q     (act_q),
    .pexc_q    (pexc_q)
  );

  logic fd_seen_q, brs_q, esi_q;

  can_fd_rx_flags u_fd (
    .clk       (clk),
    .rst_n     (rst_n),
    .ev_fd_rx  (ev_fd_rx),
    .rx_brs    (rx_brs),
    .rx_esi    (rx_esi),
    .host_rd   (host_rd),
    .fd_seen_q (fd_seen_q),
    .brs_q     (brs_q),
    .esi_q     (esi_q)
  );

  // saturating delay sum
  logic [TDC_W:0]   tdc_sum;
  logic [TDC_W-1:0] tdc_d, tdc_q;

  always_comb begin
    tdc_sum = {1'b0, tdc_meas} + {1'b0, tdc_offset};
    tdc_d   = (tdc_sum > TDC_MAX) ? TDC_MAX[TDC_W-1:0] : tdc_sum[TDC_W-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) tdc_q <= '0;
    else        tdc_q <= tdc_d;
  end

  always_comb begin
    status_word = {{PAD_W{1'b0}}, tdc_q, 1'b0, pexc_q, fd_seen_q, brs_q, esi_q,
                   field_v[FLD_DATA], busoff_q, warn_q, passive_q, act_q,
                   field_v[FLD_ARB]};
  end

  assert_tdc_bound_R11: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (status_word[16 +: TDC_W] >= $past(tdc_meas)
              && status_word[16 +: TDC_W] >= $past(tdc_offset)));
  assert_reserved_zero_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (status_word[31:23] == '0) && !status_word[15]);
endmodule

// File: tb/tb_can_status_word.sv
module tb_can_status_word;
  localparam time CLK_PERIOD = 10ns;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       host_rd, ev_ok, ev_err, in_data_phase, ev_fd_rx, rx_brs, rx_esi;
  logic       ev_pexc, ev_rec11, bus_off;
  logic [2:0] ev_err_code;
  logic [7:0] tx_err_cnt, rx_err_cnt;
  logic [1:0] act_in;
  logic [6:0] tdc_meas, tdc_offset;
  logic [31:0] status_word;

  int n_tests = 0;
  int n_fail  = 0;

  // bench-side model of the word fields
  logic [2:0] m_lec, m_dlec;
  logic       m_warn, m_pas, m_bo, m_pexc, m_fd, m_brs, m_esi;
  logic [1:0] m_act;
  logic [6:0] m_tdc;

  typedef struct { logic [31:0] exp; string tag; } item_t;
  item_t sb_q[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  can_status_word dut (
    .clk(clk), .rst_n(rst_n), .host_rd(host_rd), .ev_ok(ev_ok), .ev_err(ev_err),
    .ev_err_code(ev_err_code), .in_data_phase(in_data_phase), .ev_fd_rx(ev_fd_rx),
    .rx_brs(rx_brs), .rx_esi(rx_esi), .ev_pexc(ev_pexc), .ev_rec11(ev_rec11),
    .tx_err_cnt(tx_err_cnt), .rx_err_cnt(rx_err_cnt), .bus_off(bus_off),
    .act_in(act_in), .tdc_meas(tdc_meas), .tdc_offset(tdc_offset),
    .status_word(status_word)
  );

  function automatic logic [31:0] model_word();
    return {9'd0, m_tdc, 1'b0, m_pexc, m_fd, m_brs, m_esi, m_dlec,
            m_bo, m_warn, m_pas, m_act, m_lec};
  endfunction

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic clear_pulses();
    host_rd = 0; ev_ok = 0; ev_err = 0; ev_fd_rx = 0; ev_pexc = 0; ev_rec11 = 0;
  endtask

  // driver: inputs are already set by the caller at a negedge
  task automatic cycle(string tag);
    int s;
    if (ev_err) begin
      if (in_data_phase) m_dlec = ev_err_code; else m_lec = ev_err_code;
    end
    if (!(ev_err && !in_data_phase)) begin
      if (ev_rec11)                       m_lec = 3'd5;
      else if (ev_ok && !in_data_phase)   m_lec = 3'd0;
      else if (host_rd)                   m_lec = 3'd7;
    end
    if (!(ev_err && in_data_phase)) begin
      if (ev_ok && in_data_phase) m_dlec = 3'd0;
      else if (host_rd)           m_dlec = 3'd7;
    end
    m_warn = (tx_err_cnt >= 96) || (rx_err_cnt >= 96);
    m_pas  = ((tx_err_cnt >= 128) || (rx_err_cnt >= 128)) && !bus_off;
    m_bo   = bus_off;
    m_act  = ev_pexc ? 2'd0 : act_in;
    if (ev_pexc) m_pexc = 1'b1; else if (host_rd) m_pexc = 1'b0;
    if (ev_fd_rx) begin m_fd = 1'b1; m_brs = rx_brs; m_esi = rx_esi; end
    else if (host_rd) m_fd = 1'b0;
    s = int'(tdc_meas) + int'(tdc_offset);
    m_tdc = (s > 127) ? 7'd127 : 7'(s);
    @(posedge clk);
    sb_q.push_back('{model_word(), tag});
    @(negedge clk);
    clear_pulses();
  endtask

  // monitor: compares one clock after each driven cycle
  initial begin
    forever begin
      @(negedge clk);
      if (sb_q.size() > 0) begin
        item_t it;
        it = sb_q.pop_front();
        check(it.tag, status_word, it.exp);
      end
    end
  end

  initial begin
    #(CLK_PERIOD * 5000);
    n_tests++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    clear_pulses();
    ev_err_code = 0; in_data_phase = 0; rx_brs = 0; rx_esi = 0; bus_off = 0;
    tx_err_cnt = 0; rx_err_cnt = 0; act_in = 0; tdc_meas = 0; tdc_offset = 0;
    m_lec = 7; m_dlec = 7; m_warn = 0; m_pas = 0; m_bo = 0; m_pexc = 0;
    m_fd = 0; m_brs = 0; m_esi = 0; m_act = 0; m_tdc = 0;
    rst_n = 0;
    repeat (3) @(negedge clk);
    check("R1 reset word", status_word, 32'h0000_0707);
    rst_n = 1;
    @(negedge clk);
    check("R1 after release", status_word, 32'h0000_0707);

    ev_err = 1; ev_err_code = 3'd1; in_data_phase = 0; cycle("R2 stuff to arb field");
    ev_err = 1; ev_err_code = 3'd6; in_data_phase = 1; cycle("R3 crc to data field");
    ev_ok = 1; in_data_phase = 0;                      cycle("R4 ok clears arb field");
    ev_ok = 1; in_data_phase = 1;                      cycle("R4 ok clears data field");
    in_data_phase = 0;
    host_rd = 1;                                       cycle("R5 read resets both");
    host_rd = 1; ev_err = 1; ev_err_code = 3'd2;       cycle("R5 event beats read");
    ev_err = 1; ev_err_code = 3'd4; in_data_phase = 1; cycle("R3 bit1 data field");
    in_data_phase = 0;
    ev_rec11 = 1;                                      cycle("R6 recovery writes bit0");
    ev_ok = 1;                                         cycle("R4 ok after recovery");
    tx_err_cnt = 95; rx_err_cnt = 95;                  cycle("R7 below warning");
    tx_err_cnt = 96;                                   cycle("R7 tx at warning");
    tx_err_cnt = 0; rx_err_cnt = 100;                  cycle("R7 rx above warning");
    rx_err_cnt = 127;                                  cycle("R8 below passive");
    tx_err_cnt = 128;                                  cycle("R8 tx at passive");
    bus_off = 1; tx_err_cnt = 255;                     cycle("R8 bus-off hides passive");
    bus_off = 0; tx_err_cnt = 0; rx_err_cnt = 0;
    act_in = 2'd3;                                     cycle("R9 activity transmitter");
    act_in = 2'd2; ev_pexc = 1;                        cycle("R9 exception forces sync");
    act_in = 2'd2;                                     cycle("R9 exception sticky");
    host_rd = 1; ev_pexc = 1;                          cycle("R9 exception beats read");
    host_rd = 1;                                       cycle("R9 read clears exception");
    ev_fd_rx = 1; rx_brs = 1; rx_esi = 0;              cycle("R10 fd with brs");
    ev_fd_rx = 1; rx_brs = 0; rx_esi = 1;              cycle("R10 fd with esi");
    host_rd = 1;                                       cycle("R10 read clears fd flag");
    host_rd = 1; ev_fd_rx = 1; rx_brs = 1; rx_esi = 1; cycle("R10 fd beats read");
    tdc_meas = 20; tdc_offset = 30;                    cycle("R11 delay sum");
    tdc_meas = 100; tdc_offset = 100;                  cycle("R11 delay saturates");
    tdc_meas = 127; tdc_offset = 0;                    cycle("R11 delay at max");
    tdc_meas = 64; tdc_offset = 63;                    cycle("R11 delay sum exactly max");
    @(negedge clk);
    check("R12 reserved bits zero", status_word & 32'hFF80_8000, 32'h0);
    @(negedge clk);
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule